// File: doc/BRIEF.md
# Command Ring Control Register Logic

This block holds the control side of a host controller's command ring. It keeps a small state machine that records whether the ring is running. It accepts register writes that abort the ring, stop it or set its cycle state. When a doorbell arrives with the command reason, it starts or restarts the ring.

When the ring stops on request, the block raises a completion-event request. The request carries the "ring stopped" code and the current dequeue pointer. It stays up until the event logic accepts it. On every restart the block also supplies the cycle state for the first command fetch. Fetching, memory access and event ring writes belong to other blocks. A stubbed command engine supplies the dequeue pointer, the internal consumer cycle state and a "command done" pulse.

The state machine has three states:

| State | Meaning |
|---|---|
| IDLE_ST | Ring stopped. |
| RUN_ST | Ring running. |
| DRAIN_ST | Running, with a stop pending until the current command ends. |

It has five transitions:

| Transition | From | To | Cause | Event raised |
|---|---|---|---|---|
| T_START | IDLE_ST | RUN_ST | Doorbell with the command reason | None |
| T_ABORT | RUN_ST | IDLE_ST | Abort write | Yes |
| T_STOP_REQ | RUN_ST | DRAIN_ST | Stop write | None |
| T_DRAIN_DONE | DRAIN_ST | IDLE_ST | Command done pulse | Yes |
| T_DRAIN_ABORT | DRAIN_ST | IDLE_ST | Abort write | Yes |

Top module: `cmd_ring_ctl`

## Requirements
- R1: After reset the ring is stopped: ring_running, cmd_kill, fetch_start and evt_valid are 0, and reg_rdata is 0.
- R2: reg_rdata bits 0 (cycle state), 1 (stop) and 2 (abort) always read 0. Bit 3 shows the running flag, and every other bit reads 0.
- R3: When the ring is stopped, a doorbell whose reason equals CMD_REASON (default 0) sets ring_running in the next cycle and pulses fetch_start for exactly one cycle. A doorbell with any other reason has no effect.
- R4: A doorbell with the command reason while the ring is running leaves ring_running at 1 and produces no fetch_start.
- R5: A write with bit 2 (abort) set while the ring is running stops it in the next cycle and pulses cmd_kill. It also raises evt_valid with evt_code 24 and evt_ptr equal to deq_ptr in the write cycle.
- R6: A write with bit 1 (stop) set while running keeps ring_running at 1 until cmd_done. In the cycle after cmd_done the ring is stopped and evt_valid rises with code 24 and evt_ptr equal to deq_ptr in the cmd_done cycle. No cmd_kill is produced.
- R7: Abort and stop writes while the ring is stopped raise no event, produce no cmd_kill, and leave the ring stopped.
- R8: A single write with both bits 2 and 1 set acts as an abort and yields exactly one event. A later cmd_done yields no second event.
- R9: An abort written while a stop is pending stops the ring at once with one event. The following cmd_done adds no event.
- R10: A write to bit 0 while the ring is stopped sets the cycle state given on fetch_ccs at the next start. A write to bit 0 while the ring is running is ignored.
- R11: If no cycle state was written while stopped, fetch_ccs at start equals int_ccs. The written value is used for one start only.
- R12: evt_valid, evt_code and evt_ptr hold steady until evt_ready is sampled high. evt_valid then falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| db_valid | input | 1 | Doorbell write strobe |
| db_reason | input | REASON_W | Doorbell reason field |
| cmd_done | input | 1 | Current command finished (engine pulse) |
| int_ccs | input | 1 | Internal consumer cycle state from the engine |
| deq_ptr | input | PTR_W | Current command dequeue pointer |
| ring_running | output | 1 | Ring running flag |
| cmd_kill | output | 1 | One-cycle pulse: terminate the executing command |
| fetch_start | output | 1 | One-cycle pulse: begin fetching commands |
| fetch_ccs | output | 1 | Cycle state for the first fetch, valid with fetch_start |
| evt_valid | output | 1 | Completion event request |
| evt_ready | input | 1 | Event request accepted |
| evt_code | output | 8 | Completion code (24 = ring stopped) |
| evt_ptr | output | PTR_W | Command pointer carried by the event |

## Verification
The hardest state to reach is an abort that arrives inside DRAIN_ST. The bench has to start the ring, issue a stop, and then write abort before it pulses cmd_done. Only then can it show that the late cmd_done adds no second event. A second hard case is showing that a cycle-state write during RUN_ST had no effect. This is only visible at the next restart. The bench therefore aborts, restarts without writing, and compares fetch_ccs against int_ccs.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
    localparam int REG_W     = 32;
    localparam int CCS_BIT   = 0;
    localparam int STOP_BIT  = 1;
    localparam int ABORT_BIT = 2;
    localparam int RUN_BIT   = 3;
    localparam int CODE_W    = 8;
    localparam logic [CODE_W-1:0] CODE_RING_STOPPED = 8'd24;

    typedef enum logic [1:0] {
        IDLE_ST  = 2'd0,
        RUN_ST   = 2'd1,
        DRAIN_ST = 2'd2
    } ring_st_e;
endpackage

// File: rtl/crc_fsm.sv
module crc_fsm
    import cmd_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_wr,
    input  logic stop_wr,
    input  logic db_hit,
    input  logic cmd_done,
    output logic running,
    output logic start_now,
    output logic ev_req,
    output logic kill_q,
    output logic start_q
);
    ring_st_e state, nxt;
    logic     kill_c;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= IDLE_ST;
        else        state <= nxt;
    end

    // Next-state and transition decode.
    always_comb begin
        nxt       = state;
        ev_req    = 1'b0;
        kill_c    = 1'b0;
        start_now = 1'b0;
        unique case (state)
            IDLE_ST: begin
                if (db_hit) begin           // T_START
                    nxt       = RUN_ST;
                    start_now = 1'b1;
                end
            end
            RUN_ST: begin
                if (abort_wr) begin         // T_ABORT
                    nxt    = IDLE_ST;
                    ev_req = 1'b1;
                    kill_c = 1'b1;
                end else if (stop_wr) begin // T_STOP_REQ
                    nxt = DRAIN_ST;
                end
            end
            DRAIN_ST: begin
                if (abort_wr) begin         // T_DRAIN_ABORT
                    nxt    = IDLE_ST;
                    ev_req = 1'b1;
                    kill_c = 1'b1;
                end else if (cmd_done) begin // T_DRAIN_DONE
                    nxt    = IDLE_ST;
                    ev_req = 1'b1;
                end
            end
            default: nxt = IDLE_ST;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            kill_q  <= kill_c;
            start_q <= start_now;
        end
    end

    assign running = (state != IDLE_ST);

    // R5
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && abort_wr) |=> (!running && kill_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !db_hit) |=> (!running && !kill_q));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
endmodule

// File: rtl/crc_cycle_sel.sv
module crc_cycle_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic stopped,
    input  logic start_now,
    input  logic int_ccs,
    output logic fetch_ccs
);
    logic ccs_val;
    logic ccs_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccs_val   <= 1'b0;
            ccs_wr    <= 1'b0;
            fetch_ccs <= 1'b0;
        end else if (start_now) begin
            if (wr)          fetch_ccs <= wbit;
            else if (ccs_wr) fetch_ccs <= ccs_val;
            else             fetch_ccs <= int_ccs;
            ccs_wr <= 1'b0;
        end else if (wr && stopped) begin
            ccs_val <= wbit;
            ccs_wr  <= 1'b1;
        end
    end

    // R10
    ccs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !stopped) |=> ($stable(ccs_val) && $stable(ccs_wr)));
endmodule

// File: rtl/crc_evt_hold.sv
module crc_evt_hold
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_req,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic              evt_ready,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code,
    output logic [PTR_W-1:0]  evt_ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_ptr   <= '0;
        end else if (ev_req) begin
            evt_valid <= 1'b1;
            evt_ptr   <= ptr_in;
        end else if (evt_ready) begin
            evt_valid <= 1'b0;
        end
    end

    assign evt_code = evt_valid ? CODE_RING_STOPPED : '0;

    // R12
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready && !ev_req) |=> (evt_valid && $stable(evt_ptr)));
endmodule

// File: rtl/cmd_ring_ctl.sv
module cmd_ring_ctl
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int REASON_W   = 8,
    parameter int CMD_REASON = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                db_valid,
    input  logic [REASON_W-1:0] db_reason,
    input  logic                cmd_done,
    input  logic                int_ccs,
    input  logic [PTR_W-1:0]    deq_ptr,
    output logic                ring_running,
    output logic                cmd_kill,
    output logic                fetch_start,
    output logic                fetch_ccs,
    output logic                evt_valid,
    input  logic                evt_ready,
    output logic [CODE_W-1:0]   evt_code,
    output logic [PTR_W-1:0]    evt_ptr
);
    localparam logic [REASON_W-1:0] REASON_CMD = REASON_W'(CMD_REASON);

    logic abort_wr, stop_wr, db_hit, start_now, ev_req;

    assign abort_wr = reg_wr && reg_wdata[ABORT_BIT];
    assign stop_wr  = reg_wr && reg_wdata[STOP_BIT];
    assign db_hit   = db_valid && (db_reason == REASON_CMD);

    crc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_wr  (abort_wr),
        .stop_wr   (stop_wr),
        .db_hit    (db_hit),
        .cmd_done  (cmd_done),
        .running   (ring_running),
        .start_now (start_now),
        .ev_req    (ev_req),
        .kill_q    (cmd_kill),
        .start_q   (fetch_start)
    );

    crc_cycle_sel u_ccs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wbit      (reg_wdata[CCS_BIT]),
        .stopped   (!ring_running),
        .start_now (start_now),
        .int_ccs   (int_ccs),
        .fetch_ccs (fetch_ccs)
    );

    crc_evt_hold #(.PTR_W(PTR_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_req    (ev_req),
        .ptr_in    (deq_ptr),
        .evt_ready (evt_ready),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .evt_ptr   (evt_ptr)
    );

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[RUN_BIT] = ring_running;
    end

    // R8
    single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_running && abort_wr && stop_wr) |=> (!ring_running && evt_valid));
endmodule

// File: tb/cmd_ring_ctl_tb.sv
module cmd_ring_ctl_tb_top;
    localparam int PTR_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             db_valid = 1'b0;
    logic [7:0]       db_reason = '0;
    logic             cmd_done = 1'b0;
    logic             int_ccs = 1'b0;
    logic [PTR_W-1:0] deq_ptr = '0;
    logic             ring_running, cmd_kill, fetch_start, fetch_ccs, evt_valid;
    logic             evt_ready = 1'b1;
    logic [7:0]       evt_code;
    logic [PTR_W-1:0] evt_ptr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    cmd_ring_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .db_valid(db_valid), .db_reason(db_reason),
        .cmd_done(cmd_done), .int_ccs(int_ccs), .deq_ptr(deq_ptr),
        .ring_running(ring_running), .cmd_kill(cmd_kill),
        .fetch_start(fetch_start), .fetch_ccs(fetch_ccs),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_code(evt_code), .evt_ptr(evt_ptr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ring(input logic [7:0] r);
        @(negedge clk); db_valid = 1'b1; db_reason = r;
        step();
        db_valid = 1'b0; db_reason = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk); cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 running", ring_running, 0);
        chk("R1 evt_valid", evt_valid, 0);
        chk("R1 kill", cmd_kill, 0);
        chk("R1 fetch_start", fetch_start, 0);
        chk("R1 rdata", reg_rdata, 0);
    endtask

    task automatic t_start();
        ring(8'd5);
        chk("R3 other reason running", ring_running, 0);
        chk("R3 other reason fetch", fetch_start, 0);
        int_ccs = 1'b1;
        ring(8'd0);
        chk("R3 running", ring_running, 1);
        chk("R3 fetch_start", fetch_start, 1);
        chk("R11 fetch_ccs from int", fetch_ccs, 1);
        chk("R2 rdata running", reg_rdata, 32'h8);
        step();
        chk("R3 pulse width", fetch_start, 0);
        ring(8'd0);
        chk("R4 still running", ring_running, 1);
        chk("R4 no fetch", fetch_start, 0);
    endtask

    task automatic t_abort();
        deq_ptr = 64'h1234_5678_9ABC_DEF0;
        evt_ready = 1'b0;
        wr(32'h4);
        deq_ptr = 64'h0;
        chk("R5 stopped", ring_running, 0);
        chk("R5 kill", cmd_kill, 1);
        chk("R5 evt_valid", evt_valid, 1);
        chk("R5 code", evt_code, 24);
        chk("R5 ptr", evt_ptr, 64'h1234_5678_9ABC_DEF0);
        step();
        chk("R5 kill pulse", cmd_kill, 0);
        step();
        chk("R12 held valid", evt_valid, 1);
        chk("R12 held ptr", evt_ptr, 64'h1234_5678_9ABC_DEF0);
        @(negedge clk); evt_ready = 1'b1;
        step();
        chk("R12 accepted", evt_valid, 0);
        wr(32'hFFFF_FFF8);
        chk("R2 rdata stopped", reg_rdata, 0);
    endtask

    task automatic t_ignore_stopped();
        wr(32'h6);
        chk("R7 running", ring_running, 0);
        chk("R7 no evt", evt_valid, 0);
        chk("R7 no kill", cmd_kill, 0);
        step();
        chk("R7 no late evt", evt_valid, 0);
    endtask

    task automatic t_stop();
        ring(8'd0);
        deq_ptr = 64'hAAAA_0000_0000_0010;
        wr(32'h2);
        chk("R6 still running", ring_running, 1);
        chk("R6 no evt yet", evt_valid, 0);
        step();
        chk("R6 waits", ring_running, 1);
        deq_ptr = 64'hBBBB_0000_0000_0020;
        done_pulse();
        chk("R6 stopped", ring_running, 0);
        chk("R6 evt", evt_valid, 1);
        chk("R6 ptr", evt_ptr, 64'hBBBB_0000_0000_0020);
        chk("R6 no kill", cmd_kill, 0);
        step();
    endtask

    task automatic t_both();
        ring(8'd0);
        wr(32'h6);
        chk("R8 stopped", ring_running, 0);
        chk("R8 evt", evt_valid, 1);
        chk("R8 kill", cmd_kill, 1);
        step();
        chk("R8 one evt", evt_valid, 0);
        done_pulse();
        chk("R8 no second evt", evt_valid, 0);
    endtask

    task automatic t_abort_drain();
        ring(8'd0);
        wr(32'h2);
        chk("R9 draining", ring_running, 1);
        wr(32'h4);
        chk("R9 stopped", ring_running, 0);
        chk("R9 evt", evt_valid, 1);
        step();
        done_pulse();
        chk("R9 no second evt", evt_valid, 0);
    endtask

    task automatic t_ccs();
        int_ccs = 1'b0;
        ring(8'd0);
        chk("R11 int ccs 0", fetch_ccs, 0);
        wr(32'h1);
        wr(32'h4);
        ring(8'd0);
        chk("R10 running write ignored", fetch_ccs, 0);
        wr(32'h4);
        wr(32'h1);
        ring(8'd0);
        chk("R10 stopped write used", fetch_ccs, 1);
        wr(32'h4);
        ring(8'd0);
        chk("R11 flag cleared", fetch_ccs, 0);
        wr(32'h4);
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        step();
        t_reset();
        t_start();
        t_abort();
        t_ignore_stopped();
        t_stop();
        t_both();
        t_abort_drain();
        t_ccs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule